// File: doc/BRIEF.md
# Dual-Mode Pipeline Stage Controller

This block is one stage of a valid/ready pipeline, modelled synchronously. It owns a single data register and a token flag that marks whether the register holds a live item. A mode control picks one of two register policies. In open mode the register follows the upstream data on every cycle while the stage is empty, so a new item is already in place when it is accepted. In hold mode the register stays shut while the stage is empty and loads only when an item is actually accepted. This keeps stray upstream values from reaching the downstream logic.

The register policy never changes the handshake. Items are accepted, presented and released on the same cycles in both modes, and they come out in the same order. A requested mode switch is applied only at a safe point: on a cycle that starts with the stage empty and with nothing offered upstream. Until then the request simply waits, as long as the requester keeps it asserted. A running count of register update events lets the two policies be compared as a rough energy measure.

Top module: `dmode_stage`

## Requirements
- R1: After synchronous reset, out_valid is 0, out_data is 0, upd_count is 0 and mode_active is 1 (hold mode).
- R2: in_ready equals (not out_valid) or out_ready. An item transfers on a cycle with in_valid and in_ready both high. On the next cycle out_valid is 1 and out_data is the data that was offered.
- R3: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged on the next cycle.
- R4: In hold mode (mode_active = 1), a cycle with the stage empty and no transfer leaves out_data unchanged, whatever in_data carries.
- R5: In open mode (mode_active = 0), a cycle with the stage empty loads in_data into the register, so out_data shows it on the next cycle, while out_valid stays 0.
- R6: mode_req is encoded 0 for open mode and 1 for hold mode. mode_active takes the value of mode_req at a clock edge only when that cycle began with out_valid 0 and in_valid 0. Otherwise mode_active keeps its value.
- R7: upd_count, a wrapping counter, rises by exactly one on every edge at which out_data changes, and it holds on every other edge.
- R8: For the same in_valid/out_ready pattern, both modes accept and release items on identical cycles and deliver the same data sequence. Under continuous flow this gives one item per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested policy: 0 open, 1 hold |
| in_valid | input | 1 | Upstream item offered |
| in_data | input | DATA_W | Upstream data |
| in_ready | output | 1 | Stage can accept an item |
| out_valid | output | 1 | Stage holds an item |
| out_data | output | DATA_W | Stage register contents |
| out_ready | input | 1 | Downstream accepts the item |
| mode_active | output | 1 | Policy currently applied |
| upd_count | output | CNT_W | Count of register update events |

## Verification
A short hand-worked vector sequence covers several cases: back-pressure, draining, and mode requests made both while the stage is full and while it is idle. This separates a mode switch applied at a safe cycle from one applied too early. Idle cycles carrying changing in_data show the difference between the policies: hold mode must leave the register and counter still, while open mode must track the data and count each change. Pseudo-random valid/ready stalls and a continuous-flow pattern are each run in both modes. The transfer cycles and the data order are compared between the two, which exposes any mode dependence in the handshake.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic {
    MODE_OPEN = 1'b0,
    MODE_HOLD = 1'b1
  } lmode_e;
endpackage

// File: rtl/dms_handshake.sv
module dms_handshake (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load_tok,
  output logic full
);
  assign in_ready = !full || out_ready;
  assign load_tok = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (load_tok) begin
      full <= 1'b1;
    end else if (out_ready) begin
      full <= 1'b0;
    end
  end

  // R3
  stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !out_ready) |=> full);

  // R2
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !full |-> in_ready);
endmodule

// File: rtl/dms_mode_gate.sv
module dms_mode_gate
  import dms_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mode_req,
  input  logic   full,
  input  logic   in_valid,
  output lmode_e mode_act
);
  logic safe_pt;
  assign safe_pt = !full && !in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= MODE_HOLD;
    end else if (safe_pt) begin
      mode_act <= lmode_e'(mode_req);
    end
  end

  // R6
  mode_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (full || in_valid) |=> $stable(mode_act));
endmodule

// File: rtl/dms_data_reg.sv
module dms_data_reg
  import dms_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lmode_e            mode_act,
  input  logic              full,
  input  logic              load_tok,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] q,
  output logic              changed
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    if (load_tok) begin
      q_nxt = in_data;
    end else if (!full && mode_act == MODE_OPEN) begin
      q_nxt = in_data;
    end else begin
      q_nxt = q;
    end
  end

  assign changed = (q_nxt != q);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!full && !load_tok && mode_act == MODE_HOLD) |=> $stable(q));

  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !load_tok) |=> $stable(q));
endmodule

// File: rtl/dms_upd_counter.sv
module dms_upd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             changed,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (changed) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dmode_stage.sv
module dmode_stage
  import dms_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              mode_active,
  output logic [CNT_W-1:0]  upd_count
);
  logic   full;
  logic   load_tok;
  logic   changed;
  lmode_e mode_act;

  dms_handshake u_hs (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .load_tok (load_tok),
    .full     (full)
  );

  dms_mode_gate u_mode (
    .clk     (clk),
    .rst     (rst),
    .mode_req(mode_req),
    .full    (full),
    .in_valid(in_valid),
    .mode_act(mode_act)
  );

  dms_data_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .mode_act(mode_act),
    .full    (full),
    .load_tok(load_tok),
    .in_data (in_data),
    .q       (out_data),
    .changed (changed)
  );

  dms_upd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .changed(changed),
    .cnt    (upd_count)
  );

  assign out_valid   = full;
  assign mode_active = mode_act;

  // R2
  xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> (upd_count == $past(upd_count) + CNT_W'(1)));

  // R7
  cnt_still_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(out_data) |-> $stable(upd_count));
endmodule

// File: tb/dmode_stage_tb_top.sv
`timescale 1ns/1ps
module dmode_stage_tb_top;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;
  localparam int ITEMS  = 40;
  localparam int NVEC   = 13;

  logic              clk = 1'b0;
  logic              rst;
  logic              mode_req;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              in_ready;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_ready;
  logic              mode_active;
  logic [CNT_W-1:0]  upd_count;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dmode_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .mode_req(mode_req), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .mode_active(mode_active),
    .upd_count(upd_count)
  );

  // {mode_req, in_valid, in_data[8], out_ready, exp_ready, exp_ov, exp_od[8], exp_cnt[8], exp_mode}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 1'b1, 8'h11, 8'd1, 1'b1},
    {1'b1, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 8'h11, 8'd1, 1'b1},
    {1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 1'b1, 8'h22, 8'd2, 1'b1},
    {1'b1, 1'b0, 8'h33, 1'b1, 1'b1, 1'b0, 8'h22, 8'd2, 1'b1},
    {1'b1, 1'b0, 8'h44, 1'b1, 1'b1, 1'b0, 8'h22, 8'd2, 1'b1},
    {1'b0, 1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 8'h22, 8'd2, 1'b0},
    {1'b0, 1'b0, 8'h66, 1'b1, 1'b1, 1'b0, 8'h66, 8'd3, 1'b0},
    {1'b0, 1'b0, 8'h66, 1'b1, 1'b1, 1'b0, 8'h66, 8'd3, 1'b0},
    {1'b0, 1'b1, 8'h77, 1'b0, 1'b1, 1'b1, 8'h77, 8'd4, 1'b0},
    {1'b1, 1'b0, 8'h88, 1'b0, 1'b0, 1'b1, 8'h77, 8'd4, 1'b0},
    {1'b1, 1'b0, 8'h88, 1'b1, 1'b1, 1'b0, 8'h77, 8'd4, 1'b0},
    {1'b1, 1'b0, 8'h99, 1'b1, 1'b1, 1'b0, 8'h99, 8'd5, 1'b1},
    {1'b1, 1'b0, 8'hAA, 1'b1, 1'b1, 1'b0, 8'h99, 8'd5, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] item(input int k);
    return DATA_W'(k * 37 + 5);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mode_req = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_stream(input logic m, input int pat,
                            output logic [511:0] log, output int nout);
    logic [15:0] lfsr;
    int sent;
    int got;
    log = '0;
    @(negedge clk);
    mode_req = m; in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(mode_active == m, "R6 mode applied when idle", 32'(mode_active), 32'(m));
    lfsr = 16'hACE1; sent = 0; got = 0;
    for (int cyc = 0; cyc < 500 && got < ITEMS; cyc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (pat == 1) ? 1'b1 : lfsr[0];
      if (sent >= ITEMS) in_valid = 1'b0;
      in_data   = in_valid ? item(sent) : lfsr[15:8];
      out_ready = (pat == 1) ? 1'b1 : (lfsr[3] | lfsr[5]);
      #1;
      if (out_valid && out_ready) begin
        chk(out_data == item(got), "R8 output order", 32'(out_data), 32'(item(got)));
        got++;
        log[cyc] = 1'b1;
      end
      if (in_valid && in_ready) sent++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    nout = got;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [511:0] log_a, log_b, log_c, log_d;
    int n_a, n_b, n_c, n_d;
    logic [CNT_W-1:0] c0;
    logic [DATA_W-1:0] d0;

    rst = 1'b1; mode_req = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
    chk(out_data == '0, "R1 reset out_data", 32'(out_data), 0);
    chk(upd_count == '0, "R1 reset upd_count", 32'(upd_count), 0);
    chk(mode_active == 1'b1, "R1 reset mode", 32'(mode_active), 1);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      v = VEC[i];
      @(negedge clk);
      mode_req = v[29]; in_valid = v[28]; in_data = v[27:20]; out_ready = v[19];
      #1;
      chk(in_ready == v[18], "R2 in_ready", 32'(in_ready), 32'(v[18]));
      @(posedge clk);
      #1;
      chk(out_valid == v[17], "R2/R3 out_valid", 32'(out_valid), 32'(v[17]));
      chk(out_data == v[16:9], "R3/R4/R5 out_data", 32'(out_data), 32'(v[16:9]));
      chk(upd_count == CNT_W'(v[8:1]), "R7 upd_count", 32'(upd_count), 32'(v[8:1]));
      chk(mode_active == v[0], "R6 mode_active", 32'(mode_active), 32'(v[0]));
    end

    // R4: hold mode idle, changing data leaves register and count
    do_reset();
    out_ready = 1'b1;
    @(negedge clk);
    c0 = upd_count; d0 = out_data;
    for (int k = 0; k < 5; k++) begin
      in_data = DATA_W'(8'hC0 + k);
      @(negedge clk);
    end
    chk(out_data == d0, "R4 hold idle data", 32'(out_data), 32'(d0));
    chk(upd_count == c0, "R4 hold idle count", 32'(upd_count), 32'(c0));

    // R5 R7: open mode idle tracks data, counts each change
    mode_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    c0 = upd_count;
    for (int k = 0; k < 5; k++) begin
      in_data = DATA_W'(8'hD0 + k);
      @(negedge clk);
      chk(out_data == DATA_W'(8'hD0 + k), "R5 open idle tracks", 32'(out_data), 32'(8'hD0 + k));
      chk(out_valid == 1'b0, "R5 open idle no valid", 32'(out_valid), 0);
    end
    chk(upd_count == c0 + CNT_W'(5), "R7 open idle count", 32'(upd_count), 32'(c0 + 5));

    // R8: random stalls and continuous flow in both modes
    do_reset();
    run_stream(1'b1, 0, log_a, n_a);
    run_stream(1'b0, 0, log_b, n_b);
    chk(n_a == ITEMS, "R8 hold random count", n_a, ITEMS);
    chk(n_b == ITEMS, "R8 open random count", n_b, ITEMS);
    chk(log_a == log_b, "R8 random transfer cycles match", 32'(log_a[31:0]), 32'(log_b[31:0]));
    run_stream(1'b1, 1, log_c, n_c);
    run_stream(1'b0, 1, log_d, n_d);
    chk(log_c == log_d, "R8 full flow cycles match", 32'(log_c[31:0]), 32'(log_d[31:0]));
    chk($countones(log_c[ITEMS:0]) == ITEMS, "R8 full flow one per cycle",
        32'($countones(log_c[ITEMS:0])), ITEMS);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule